// File: doc/BRIEF.md
# Wakeup Clock Stabilisation Timer

This block decides when the core clocks of a chip may run again after a halt. While the chip runs, the core clock enable is high. A halt request drops it. A later wakeup request starts a stabilisation wait. During that wait only the oscillator path and this timer are active. The wait is measured in instruction-cycle ticks, and each tick is one division of the oscillator clock by a fixed ratio. A down counter starts from a fixed preset and takes one step per tick. When the count runs out, the core clock enable is raised again.

The oscillator is modelled as the input clock plus a qualified valid input. The timer only moves on cycles where that input is high, so a weak oscillator lengthens the wait. A strap selects RC-clock mode. In that mode a software delay-enable flag chooses between the full wait and an immediate restart. The flag is held cleared by its owner at reset. A single-cycle ready pulse marks each return to running. Wakeups that arrive outside the halted state are ignored.

Top module: `wake_stab_timer`

## Requirements
- R1: During and straight after reset, core_clk_en_o is 1 and ready_o is 0. The block starts in the running state.
- R2: While running, halt_i = 1 at a clock edge makes core_clk_en_o 0 from the next cycle on.
- R3: A wakeup accepted in halt with rc_mode_i = 0, or with rc_mode_i = 1 and dly_en_i = 1, keeps core_clk_en_o at 0 for exactly DIV*PRESET cycles with osc_ok_i = 1. It rises in the cycle after the last of them. With the defaults this is 2560 cycles. The prescaler is cleared when the wakeup is accepted.
- R4: A cycle with osc_ok_i = 0 during the wait does not advance the timer. Each such cycle lengthens the wait by one cycle.
- R5: A wakeup accepted in halt with rc_mode_i = 1 and dly_en_i = 0 sets core_clk_en_o to 1 in the next cycle.
- R6: ready_o is a one-cycle pulse. It is high exactly in the first cycle of core_clk_en_o = 1 after a halt, and at no other time.
- R7: wake_req_i has no effect while running or during the wait. It neither restarts nor shortens the delay.
- R8: halt_i has no effect in the halted state or during the wait. In the halted state, with no wakeup, core_clk_en_o stays 0.
- R9: rc_mode_i and dly_en_i are sampled only when the wakeup is accepted. Changing them during the wait does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_ok_i | input | 1 | Oscillator amplitude qualified; timer advances only when 1 |
| halt_i | input | 1 | Request to stop the core clocks |
| wake_req_i | input | 1 | Wakeup request |
| rc_mode_i | input | 1 | Strap: 1 selects RC-clock mode |
| dly_en_i | input | 1 | Software flag: in RC mode, 1 inserts the startup delay |
| core_clk_en_o | output | 1 | Enable for the core clocks |
| ready_o | output | 1 | One-cycle pulse when the core clocks restart |

## Verification
The bench builds the block with its defaults: a divide ratio of 10 and a preset of 256. These give a full wait of 2560 qualified cycles. That wait is short enough to run a dozen complete wakeups with oscillator dropouts, and still land on the exact restart cycle each time. The real ratio and preset keep the last-tick and prescaler-wrap timing at the values the block ships with. Random dropouts and stray halt, wakeup and mode changes during the wait show that only qualified cycles count.

// File: rtl/wst_pkg.sv
package wst_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WAIT = 2'd2
  } wst_state_e;
endpackage

// File: rtl/wst_prescaler.sv
module wst_prescaler #(
  parameter int unsigned DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      logic unused_clr;
      assign unused_clr = clr_i ^ clk_i ^ rst_ni;
      assign tick_o = en_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap = (pre_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pre_q <= '0;
        else if (clr_i)   pre_q <= '0;
        else if (en_i)    pre_q <= wrap ? '0 : pre_q + 1'b1;
      end
      assign tick_o = en_i & wrap;
    end
  endgenerate
endmodule

// File: rtl/wst_down_counter.sv
module wst_down_counter #(
  parameter int unsigned PRESET = 256,
  parameter int unsigned CW     = $clog2(PRESET + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= CW'(PRESET);
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/wst_ctrl.sv
module wst_ctrl
  import wst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       wake_i,
  input  logic       rc_i,
  input  logic       dly_en_i,
  input  logic       done_i,
  output wst_state_e state_o,
  output logic       load_o,
  output logic       core_en_o,
  output logic       ready_o
);
  wst_state_e state_q, state_d;
  logic       ready_q, skip_dly;

  assign skip_dly = rc_i & ~dly_en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (halt_i) state_d = ST_HALT;
      ST_HALT: if (wake_i) state_d = skip_dly ? ST_RUN : ST_WAIT;
      ST_WAIT: if (done_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_q != ST_RUN) && (state_d == ST_RUN);
    end
  end

  assign load_o    = (state_q == ST_HALT) & wake_i & ~skip_dly;
  assign state_o   = state_q;
  assign core_en_o = (state_q == ST_RUN);
  assign ready_o   = ready_q;
endmodule

// File: rtl/wake_stab_timer.sv
module wake_stab_timer
  import wst_pkg::*;
#(
  parameter int unsigned DIV    = 10,
  parameter int unsigned PRESET = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_ok_i,
  input  logic halt_i,
  input  logic wake_req_i,
  input  logic rc_mode_i,
  input  logic dly_en_i,
  output logic core_clk_en_o,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(PRESET + 1);

  wst_state_e    state_q;
  logic          load, pre_en, tick, last, done;
  logic [CW-1:0] cnt_val;

  assign pre_en = (state_q == ST_WAIT) & osc_ok_i;
  assign done   = tick & last;

  wst_prescaler #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .en_i   (pre_en),
    .tick_o (tick)
  );

  wst_down_counter #(.PRESET(PRESET), .CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dec_i  (tick),
    .cnt_o  (cnt_val),
    .last_o (last)
  );

  wst_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt_i),
    .wake_i    (wake_req_i),
    .rc_i      (rc_mode_i),
    .dly_en_i  (dly_en_i),
    .done_i    (done),
    .state_o   (state_q),
    .load_o    (load),
    .core_en_o (core_clk_en_o),
    .ready_o   (ready_o)
  );
endmodule

// File: rtl/wst_checker.sv
module wst_checker
  import wst_pkg::*;
#(
  parameter int unsigned DIV    = 10,
  parameter int unsigned PRESET = 256,
  parameter int unsigned CW     = $clog2(PRESET + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          osc_ok_i,
  input logic          halt_i,
  input logic          wake_req_i,
  input logic          rc_mode_i,
  input logic          dly_en_i,
  input logic          core_clk_en_o,
  input logic          ready_o,
  input wst_state_e    state_q,
  input logic [CW-1:0] cnt_val
);
  localparam int unsigned TOTAL = DIV * PRESET;
  localparam int unsigned TW    = $clog2(TOTAL + 1) + 1;

  logic [TW-1:0] vcnt;
  logic          at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              vcnt <= '0;
    else if (state_q != ST_WAIT)              vcnt <= '0;
    else if (osc_ok_i)                        vcnt <= vcnt + 1'b1;
  end
  assign at_end = osc_ok_i && (vcnt == TW'(TOTAL - 1));

  always @(posedge clk_i)
    if (!rst_ni) p_reset_r1: assert (core_clk_en_o && !ready_o);

  p_halt_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && halt_i |=> !core_clk_en_o);
  p_exact_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT && at_end |=> core_clk_en_o && ready_o);
  p_osc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT && !osc_ok_i |=> $stable(cnt_val));
  p_rc_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT && wake_req_i && rc_mode_i && !dly_en_i |=> core_clk_en_o && ready_o);
  p_ready_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_ready_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> core_clk_en_o && !$past(core_clk_en_o));
  p_run_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && !halt_i |=> core_clk_en_o && !ready_o);
  p_halt_stay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT && !wake_req_i |=> state_q == ST_HALT && !core_clk_en_o);
  p_no_early_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT && !at_end |=> state_q == ST_WAIT);
endmodule

bind wake_stab_timer wst_checker #(.DIV(DIV), .PRESET(PRESET)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .osc_ok_i      (osc_ok_i),
  .halt_i        (halt_i),
  .wake_req_i    (wake_req_i),
  .rc_mode_i     (rc_mode_i),
  .dly_en_i      (dly_en_i),
  .core_clk_en_o (core_clk_en_o),
  .ready_o       (ready_o),
  .state_q       (state_q),
  .cnt_val       (cnt_val)
);

// File: tb/sim_wake_stab_timer.sv
`timescale 1ns/1ps
module sim_wake_stab_timer;
  localparam int DIV    = 10;
  localparam int PRESET = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic osc_ok, halt, wake, rc, dly;
  logic core_en, rdy;

  int errors = 0, checks = 0;
  bit finished = 0;

  // Reference: 0 run, 1 halt, 2 wait
  int m_st = 0, m_left = 0;
  logic exp_en = 1'b1, exp_rdy = 1'b0;

  always #4 clk = ~clk;

  wake_stab_timer #(.DIV(DIV), .PRESET(PRESET)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .osc_ok_i(osc_ok), .halt_i(halt),
    .wake_req_i(wake), .rc_mode_i(rc), .dly_en_i(dly),
    .core_clk_en_o(core_en), .ready_o(rdy)
  );

  function automatic int full_wait();
    return DIV * PRESET;
  endfunction

  task automatic check_out(input string tag);
    checks++;
    if (core_en !== exp_en) begin
      errors++;
      $display("FAIL %s core_clk_en_o got %0b exp %0b at %0t", tag, core_en, exp_en, $time);
    end
    checks++;
    if (rdy !== exp_rdy) begin
      errors++;
      $display("FAIL R6 (%s) ready_o got %0b exp %0b at %0t", tag, rdy, exp_rdy, $time);
    end
  endtask

  task automatic step(input logic h, w, r, d, o, input string tag);
    @(negedge clk);
    check_out(tag);
    halt = h; wake = w; rc = r; dly = d; osc_ok = o;
    exp_rdy = 1'b0;
    case (m_st)
      0: if (h) m_st = 1;
      1: if (w) begin
           if (r && !d) begin m_st = 0; exp_rdy = 1'b1; end
           else begin m_st = 2; m_left = full_wait(); end
         end
      default: if (o) begin
           m_left--;
           if (m_left == 0) begin m_st = 0; exp_rdy = 1'b1; end
         end
    endcase
    exp_en = (m_st == 0);
  endtask

  function automatic logic rb();
    return logic'($urandom_range(0, 1));
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    halt = 0; wake = 0; rc = 0; dly = 0; osc_ok = 1;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R1 in reset");
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 1, "R1");

    // wake while running is ignored
    for (int i = 0; i < 20; i++) step(0, rb(), rb(), rb(), rb(), "R7 run");

    // halt then crystal-mode wake with steady oscillator
    step(1, 0, 0, 0, 1, "R2");
    for (int i = 0; i < 5; i++) step(rb(), 0, rb(), rb(), rb(), "R2 R8");
    step(0, 1, 0, 0, 1, "R3");
    for (int i = 0; i < full_wait() + 4; i++) step(0, 0, 0, 0, 1, "R3");

    // RC mode, delay disabled: immediate restart
    step(1, 0, 1, 0, 1, "R2");
    step(0, 0, 1, 0, 1, "R8");
    step(0, 1, 1, 0, 1, "R5");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 1, "R5");

    // RC mode, delay enabled, dropouts and stray inputs during wait
    step(1, 0, 1, 1, 1, "R2");
    step(0, 1, 1, 1, 1, "R3 R9");
    while (m_st != 0)
      step(rb(), rb(), rb(), rb(), ($urandom_range(0, 3) != 0), "R4 R7 R8 R9");
    for (int i = 0; i < 3; i++) step(0, rb(), rb(), rb(), rb(), "R7");

    // random wakeups
    for (int k = 0; k < 10; k++) begin
      step(1, 0, rb(), rb(), rb(), "R2");
      for (int i = 0; i < int'($urandom_range(0, 6)); i++)
        step(rb(), 0, rb(), rb(), rb(), "R8");
      step(0, 1, rb(), rb(), rb(), "R3 R5");
      while (m_st != 0)
        step(rb(), rb(), rb(), rb(), ($urandom_range(0, 4) != 0), "R3 R4 R9");
      for (int i = 0; i < 3; i++) step(0, rb(), rb(), rb(), rb(), "R6 R7");
    end

    step(0, 0, 0, 0, 1, "R6");
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog (R3 R4) got timeout exp completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule